// File: doc/BRIEF.md
# STN Panel Scan Engine

This block is the back end of a display controller for single-scan monochrome STN panels. It reads the frame buffer from memory one 32-bit word at a time through a simple read-request port. It unpacks each word into pixels at 1, 2 or 4 bits per pixel and drives four pixels at a time onto a 4-bit panel data bus. It also produces the panel's pixel clock, line clock, first-line marker and AC-bias toggle. At 2 and 4 bits per pixel, a grey level is turned into on/off dots by comparing it against a free-running frame counter. This gives a simple time-based greyscale.

Software writes the frame-buffer base, the panel width in 16-pixel units, the line count and the depth code, and then raises `enable`. The engine copies all four settings at the start of every frame. A change made part-way through a frame therefore applies from the next frame on. Lowering `enable` stops the scan within one cycle. Raising it again starts a fresh frame at the base address.

Top module: `stn_scan_engine`

## Requirements
- R1: While `rst_n` is low, and from the cycle after `enable` is seen low, `mem_req`, `pix_clk`, `line_clk`, `frame_pulse` and `pix_data` are all 0. After reset `ac_bias` is 0.
- R2: Read addresses within a frame form a sequence of words starting at the latched base. The k-th read of a frame goes to `{base[31:17], (base[16:0] + 4*k) mod 2^17}`, so reads wrap inside the aligned 128 KB window. `mem_req` and `mem_addr` hold steady until `mem_valid` is returned.
- R3: Pixels are taken from each word starting at bit 0 and moving upward. Pixel n of the frame begins at bit n*d of the frame's bit stream, where d is the depth. On each `pix_clk` pulse, `pix_data[i]` carries pixel 4g+i, where g is the group number. Depth code 0 selects 1 bit, code 1 selects 2 bits, and codes 2 and 3 select 4 bits per pixel.
- R4: At 1 bit per pixel, the bit is shown as it is. At depth d of 2 or 4, a pixel of value v is shown as 1 when v > (F mod 2^d), where F is the frame count. F is 0 after reset and is counted in 4 bits.
- R5: Each line has exactly (`cfg_width`+1)*4 `pix_clk` pulses, which is 16*(`cfg_width`+1) pixels. These are followed by one `line_clk` pulse that lasts one cycle.
- R6: A frame has `cfg_lines`+1 lines. `frame_pulse` is high only during the `line_clk` pulse of line 0 of each frame.
- R7: `ac_bias` flips once per frame, on the cycle that follows the `line_clk` pulse of the frame's last line, and at no other time.
- R8: The base, width, line count and depth are captured when a frame starts. A new `cfg_base` written during a frame is first used by the next frame.
- R9: Each `pix_clk` pulse is preceded by a cycle in which `pix_data` already shows the same value, and `pix_data` does not change while `pix_clk` is high.
- R10: Raising `enable` again after it was dropped part-way through a frame starts a new frame at the base, with line 0. The frame counter and `ac_bias` are not reset by this.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the scan |
| cfg_base | input | 32 | Frame-buffer byte base (word aligned) |
| cfg_width | input | 6 | Panel width in 16-pixel units minus one |
| cfg_lines | input | 10 | Lines per frame minus one |
| cfg_depth | input | 2 | Depth code: 0=1, 1=2, 2/3=4 bits per pixel |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read byte address |
| mem_valid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data word |
| pix_clk | output | 1 | Pixel clock, one pulse per four pixels |
| line_clk | output | 1 | Line clock pulse |
| frame_pulse | output | 1 | High during the first line's line clock |
| ac_bias | output | 1 | AC-bias toggle |
| pix_data | output | 4 | Four pixels, earliest pixel in bit 0 |

## Verification
With a single-line frame, the line clock that marks the first line is also the end of the frame. In that one cycle `frame_pulse` must be high, and the next cycle must flip `ac_bias`, advance the greyscale counter and restart the address at the base. The sweep includes `cfg_lines` = 0 at every depth to bring these events together. At each line clock the bench checks the marker and the bias level, and it checks the following frame's first read address and pixel values against arithmetic built from the frame count.

// File: rtl/stn_scan_engine.sv
module stn_scan_engine #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 17,
  parameter int WID_W  = 6,
  parameter int LIN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic [LIN_W-1:0]  cfg_lines,
  input  logic [1:0]        cfg_depth,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [31:0]       mem_rdata,
  output logic              pix_clk,
  output logic              line_clk,
  output logic              frame_pulse,
  output logic              ac_bias,
  output logic [3:0]        pix_data
);
  localparam int GRP_W = WID_W + 3;

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_SETUP, ST_HIGH, ST_LINE} st_t;
  st_t st;

  logic [ADDR_W-1:0] base_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [WID_W-1:0]  wid_q;
  logic [LIN_W-1:0]  lines_q, line_idx;
  logic [1:0]        dep_q;
  logic [31:0]       sr, sr_next;
  logic [3:0]        word_left, word_grps;
  logic [GRP_W-1:0]  line_left;
  logic [3:0]        fc;
  logic [3:0]        grey;

  wire last_line = (line_idx == lines_q);
  wire showing   = (st == ST_SETUP) || (st == ST_HIGH);

  assign mem_req     = (st == ST_FETCH);
  assign mem_addr    = {base_q[ADDR_W-1:OFS_W], base_q[OFS_W-1:0] + ofs_q};
  assign pix_clk     = (st == ST_HIGH);
  assign line_clk    = (st == ST_LINE);
  assign frame_pulse = line_clk && (line_idx == '0);
  assign pix_data    = showing ? grey : 4'd0;

  assign word_grps = (dep_q == 2'd0) ? 4'd8 : (dep_q == 2'd1) ? 4'd4 : 4'd2;

  always_comb begin
    case (dep_q)
      2'd0:    sr_next = sr >> 4;
      2'd1:    sr_next = sr >> 8;
      default: sr_next = sr >> 16;
    endcase
  end

  always_comb begin
    grey = '0;
    for (int i = 0; i < 4; i++) begin
      case (dep_q)
        2'd0:    grey[i] = sr[i];
        2'd1:    grey[i] = (sr[2*i +: 2] > fc[1:0]);
        default: grey[i] = (sr[4*i +: 4] > fc);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      base_q    <= '0;
      ofs_q     <= '0;
      wid_q     <= '0;
      lines_q   <= '0;
      line_idx  <= '0;
      dep_q     <= '0;
      sr        <= '0;
      word_left <= '0;
      line_left <= '0;
      fc        <= '0;
      ac_bias   <= 1'b0;
    end else if (!enable) begin
      st <= ST_IDLE;
    end else begin
      if (st == ST_IDLE || (st == ST_LINE && last_line)) begin
        base_q    <= cfg_base;
        wid_q     <= cfg_width;
        lines_q   <= cfg_lines;
        dep_q     <= cfg_depth;
        ofs_q     <= '0;
        line_idx  <= '0;
        word_left <= '0;
        line_left <= GRP_W'({cfg_width, 2'b00}) + GRP_W'(4);
      end
      case (st)
        ST_IDLE: st <= ST_FETCH;
        ST_FETCH: begin
          if (mem_valid) begin
            sr        <= mem_rdata;
            word_left <= word_grps;
            ofs_q     <= ofs_q + OFS_W'(4);
            st        <= ST_SETUP;
          end
        end
        ST_SETUP: st <= ST_HIGH;
        ST_HIGH: begin
          sr        <= sr_next;
          word_left <= word_left - 4'd1;
          line_left <= line_left - GRP_W'(1);
          if (line_left == GRP_W'(1))      st <= ST_LINE;
          else if (word_left == 4'd1)      st <= ST_FETCH;
          else                             st <= ST_SETUP;
        end
        ST_LINE: begin
          if (last_line) begin
            fc      <= fc + 4'd1;
            ac_bias <= ~ac_bias;
            st      <= ST_FETCH;
          end else begin
            line_idx  <= line_idx + LIN_W'(1);
            line_left <= GRP_W'({wid_q, 2'b00}) + GRP_W'(4);
            st        <= (word_left == 4'd0) ? ST_FETCH : ST_SETUP;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_idle_after_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!mem_req && !pix_clk && !line_clk && pix_data == 4'd0));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid && enable) |=> (mem_req && $stable(mem_addr)));

  assert_line_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_clk |=> !line_clk);

  assert_frame_inside_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> line_clk);

  assert_bias_after_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_bias != $past(ac_bias)) |-> $past(line_clk));

  assert_data_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_clk |-> $stable(pix_data));
endmodule

// File: tb/sim_stn_scan_engine.sv
module sim_stn_scan_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [31:0] cfg_base = 32'h0;
  logic [5:0]  cfg_width = 6'd0;
  logic [9:0]  cfg_lines = 10'd0;
  logic [1:0]  cfg_depth = 2'd0;
  logic mem_req, mem_valid, pix_clk, line_clk, frame_pulse, ac_bias;
  logic [31:0] mem_addr, mem_rdata;
  logic [3:0]  pix_data;

  always #5 clk = ~clk;

  stn_scan_engine u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_base(cfg_base),
    .cfg_width(cfg_width), .cfg_lines(cfg_lines), .cfg_depth(cfg_depth),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .pix_clk(pix_clk), .line_clk(line_clk),
    .frame_pulse(frame_pulse), .ac_bias(ac_bias), .pix_data(pix_data));

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ {a[15:0], a[31:16]};
  endfunction

  // memory model: two-cycle latency
  logic busy = 0;
  logic [1:0] cnt = 0;
  logic [31:0] ma = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0; busy <= 1'b0; mem_rdata <= 32'h0;
    end else if (mem_valid) begin
      mem_valid <= 1'b0; busy <= 1'b0;
    end else if (busy) begin
      if (cnt == 0) begin mem_valid <= 1'b1; mem_rdata <= memf(ma); end
      else cnt <= cnt - 2'd1;
    end else if (mem_req) begin
      busy <= 1'b1; ma <= mem_addr; cnt <= 2'd1;
    end
  end

  // monitor state
  bit m_run = 0;
  logic [31:0] m_base;
  int m_w, m_l, m_bits;
  int p, grp, line_no, fetch_k;
  int fnum = 0;
  int total_frames = 0;
  int total_lines = 0;

  function automatic int bits_of(input logic [1:0] d);
    return (d == 2'd0) ? 1 : (d == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_addr(input int k);
    logic [16:0] lo;
    lo = 17'(m_base[16:0] + 17'(4 * k));
    return {m_base[31:17], lo};
  endfunction

  function automatic logic [3:0] exp_group(input int pp);
    logic [3:0] g;
    for (int i = 0; i < 4; i++) begin
      int bp, k, off, mask, v;
      bp = (pp + i) * m_bits;
      k = bp / 32;
      off = bp % 32;
      mask = (1 << m_bits) - 1;
      v = int'((memf(exp_addr(k)) >> off)) & mask;
      g[i] = (m_bits == 1) ? v[0] : (v > (fnum & mask));
    end
    return g;
  endfunction

  task automatic latch_cfg();
    m_base = cfg_base; m_w = int'(cfg_width); m_l = int'(cfg_lines);
    m_bits = bits_of(cfg_depth);
    p = 0; grp = 0; line_no = 0; fetch_k = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      fnum = 0; m_run = 0;
    end else if (!enable) begin
      m_run = 0;
    end else begin
      if (!m_run) begin latch_cfg(); m_run = 1; end
      if (mem_req && mem_valid) begin
        check(mem_addr == exp_addr(fetch_k), "R2 fetch address", mem_addr, exp_addr(fetch_k));
        fetch_k++;
      end
      if (pix_clk) begin
        check(pix_data == exp_group(p), "R3/R4 pixel group", 32'(pix_data), 32'(exp_group(p)));
        p += 4; grp++;
      end
      if (line_clk) begin
        check(grp == (m_w + 1) * 4, "R5 groups per line", grp, (m_w + 1) * 4);
        check(frame_pulse == (line_no == 0), "R6 frame pulse", 32'(frame_pulse), 32'(line_no == 0));
        check(ac_bias == fnum[0], "R7 ac bias level", 32'(ac_bias), 32'(fnum[0]));
        grp = 0; line_no++; total_lines++;
        if (line_no > m_l) begin
          fnum++; total_frames++;
          latch_cfg(); // R8: settings picked up only here
        end
      end
    end
  end

  task automatic do_reset();
    enable = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
  endtask

  task automatic run(input logic [1:0] d, input logic [5:0] w, input logic [9:0] l,
                     input logic [31:0] b, input int frames, input bit rst);
    int start;
    if (rst) do_reset();
    @(posedge clk); #2;
    cfg_depth = d; cfg_width = w; cfg_lines = l; cfg_base = b;
    start = total_frames;
    enable = 1;
    wait (total_frames >= start + frames);
    @(posedge clk); #2 enable = 0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: idle after reset with enable low
    repeat (3) begin
      @(negedge clk);
      check(!mem_req && !pix_clk && !line_clk && !frame_pulse && pix_data == 0 && !ac_bias,
            "R1 reset idle", {mem_req, pix_clk, line_clk, frame_pulse, ac_bias, pix_data}, 0);
    end
    // sweep: depths x widths x line counts (lines=1 merges first and last line)
    for (int d = 0; d < 4; d++)
      for (int w = 0; w < 2; w++)
        for (int li = 0; li < 2; li++)
          run(2'(d), 6'(w), (li == 0) ? 10'd0 : 10'd2, 32'h0000_0400 + 32'(d * 32'h100),
              (d >= 2) ? 18 : (d == 1 ? 5 : 3), 1);
    // R8: base changed mid-frame
    begin
      int s;
      do_reset();
      @(posedge clk); #2;
      cfg_depth = 2'd1; cfg_width = 6'd0; cfg_lines = 10'd3; cfg_base = 32'h0000_2000;
      s = total_lines; enable = 1;
      wait (total_lines >= s + 1);
      @(posedge clk); #2 cfg_base = 32'h0000_6000;
      s = total_frames;
      wait (total_frames >= s + 3);
      @(posedge clk); #2 enable = 0;
      repeat (4) @(posedge clk);
    end
    // R2: window wrap at 128 KB
    run(2'd2, 6'd1, 10'd2, 32'h0003_FFF0, 2, 1);
    // R1/R10: drop enable mid-frame, stay idle, restart without reset
    begin
      int s;
      do_reset();
      @(posedge clk); #2;
      cfg_depth = 2'd0; cfg_width = 6'd1; cfg_lines = 10'd1; cfg_base = 32'h0000_0800;
      s = total_frames; enable = 1;
      wait (total_frames >= s + 1);
      repeat (30) @(posedge clk);
      #2 enable = 0;
      @(posedge clk);
      repeat (16) begin
        @(negedge clk);
        check(!mem_req && !pix_clk && !line_clk && pix_data == 0, "R1 idle after disable",
              {mem_req, pix_clk, line_clk, pix_data}, 0);
      end
      check(ac_bias == 1'b1, "R10 bias kept over disable", 32'(ac_bias), 1);
      @(posedge clk); #2;
      s = total_frames; enable = 1;   // R10: fresh frame from base, counter kept
      wait (total_frames >= s + 2);
      @(posedge clk); #2 enable = 0;
      repeat (4) @(posedge clk);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule